// File: doc/BRIEF.md
# Contactless Command Frame Receiver

This block sits behind the envelope demodulator of a contactless tag. It sees one sampled line level per bit-time: level 0 means the reader is modulating the carrier. A one-cycle strobe marks each valid sample. The block watches for a start-of-frame marker inside a short listening window. It then unpacks the framed characters into bytes and recognises the end-of-frame marker. At that point it reports the byte count, a framing verdict and a CRC verdict.

The byte output is a valid-only stream. The line cannot be stalled, so there is no ready input and no back-pressure. Each byte is presented for exactly one cycle, and the sink must take it in that cycle. `byte_first` marks the command byte. The frame status outputs are refreshed when `frame_done` pulses and are held until the next frame ends. After a cleanly framed frame, `reply_start` pulses at the bit-time when the tag's answer must begin. The next listening window is held off until that pulse has been issued.

All outputs are registered. A strobe at clock cycle N affects the outputs from cycle N+1.

Top module: `tag_cmd_rx`

## Requirements
- R1: A frame opens with 10 or 11 low samples followed by 2 or 3 high samples. The next low sample is the first start bit. Fewer or more lows, or fewer or more highs, end the frame at once with `frame_done` and `frame_err`=1.
- R2: Each character is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit. Each completed character appears on `byte_data` with a one-cycle `byte_valid`. `byte_first` is 1 only for the first byte of the frame.
- R3: After a stop bit, 0 to 6 extra high guard samples may come before the next start bit. A seventh guard sample ends the frame with `frame_err`=1.
- R4: A run of 10 or 11 low samples that begins where a start bit may appear, followed by a high sample, ends the frame. The result is `frame_done` with `frame_err`=0 and `frame_len` equal to the byte count. A twelfth low sample, or a low stop slot after nonzero data bits, sets `frame_err`=1.
- R5: The CRC register starts at 0xFFFF and uses polynomial 0x1021, shifted towards the MSB. It is fed only the data bits of accepted bytes, in line order. The sender appends its register bits from bit 15 down to bit 0. `crc_ok` is 1 only when the register is zero at the end of the frame and the frame holds at least 3 bytes.
- R6: When `crc_off` is 1, `crc_ok` is 1 for every cleanly ended frame.
- R7: `reply_start` pulses one cycle after the strobe that falls 12 bit-times after the first low sample of the end marker. It pulses only for frames ended with `frame_err`=0.
- R8: A `listen_open` pulse opens a window of the next 8 strobes. A frame is accepted only if its first low follows a high sample at window positions 1 to 6. A first low at position 0 or 7 is ignored: nothing is output, and a later frame is received normally.
- R9: Line activity while no window is open produces no bytes, no `frame_done` and no `reply_start`.
- R10: At most 40 bytes are delivered per frame. Bytes beyond that are dropped, `frame_len` stays at 40, and `overflow` is set at the end of the frame.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle marker of a valid line sample |
| rx_lvl | input | 1 | Sampled envelope, 0 = carrier modulated |
| listen_open | input | 1 | Pulse that opens a listening window |
| crc_off | input | 1 | 1 disables the CRC verdict |
| byte_valid | output | 1 | Received byte present this cycle |
| byte_data | output | 8 | Received byte |
| byte_first | output | 1 | Byte is the first of its frame |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_len | output | 6 | Bytes delivered in the last frame |
| frame_err | output | 1 | Last frame ended on a framing fault |
| crc_ok | output | 1 | Last frame passed the CRC check |
| overflow | output | 1 | Last frame exceeded the byte limit |
| reply_start | output | 1 | Reply must begin now |

## Verification
On every cycle, the assertions check several properties. Bytes and replies appear only right after a strobe. A byte never coincides with the end-of-frame pulse. The reported length never exceeds the limit. A frame begins only while a window is open. A faulty frame is never followed by a reply pulse.

Only the bench scenarios can show the rest. These include the exact accept and reject boundaries of the start, guard and end runs, and the byte values and first-byte marking. They also cover the CRC verdict on intact and corrupted frames, and the 12-bit-time reply instant. Finally, they show that ignored modulation leaves the receiver able to take the next frame.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOT_LO,
    ST_SOT_HI,
    ST_DATA,
    ST_GUARD,
    ST_EOT
  } rx_state_e;

  // character geometry: start + data + stop
  localparam int CHAR_BITS    = 8;
  localparam int STOP_SLOT    = CHAR_BITS + 1;
  // an end marker is recognised at the stop slot of an all-zero character
  localparam int EOT_LO_SHORT = CHAR_BITS + 2;
  localparam int EOT_LO_LONG  = CHAR_BITS + 3;
endpackage

// File: rtl/tcr_crc.sv
module tcr_crc #(
  parameter int              CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter int              DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_nxt;

  // bits enter in line order: din[0] first
  always_comb begin
    crc_nxt = crc;
    for (int i = 0; i < DATA_W; i++) begin
      if (crc_nxt[CRC_W-1] ^ din[i])
        crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else
        crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_INIT;
    else if (init) crc <= CRC_INIT;
    else if (en)   crc <= crc_nxt;
  end
endmodule

// File: rtl/tcr_listen.sv
module tcr_listen #(
  parameter int LISTEN_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_lvl,
  input  logic open_req,
  input  logic busy,
  output logic win_active,
  output logic sot_go
);
  localparam int SLOT_W = $clog2(LISTEN_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LISTEN_BITS - 1);

  logic [SLOT_W-1:0] slot;
  logic              prev_hi;

  // a start edge counts only after a high sample and away from both window ends
  assign sot_go = win_active && bit_stb && !rx_lvl && prev_hi &&
                  (slot != '0) && (slot != LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_active <= 1'b0;
      slot       <= '0;
      prev_hi    <= 1'b0;
    end else if (open_req && !busy && !win_active) begin
      win_active <= 1'b1;
      slot       <= '0;
      prev_hi    <= 1'b0;
    end else if (win_active && bit_stb) begin
      if (sot_go || slot == LAST_SLOT) win_active <= 1'b0;
      slot    <= slot + 1'b1;
      prev_hi <= rx_lvl;
    end
  end

  assert_window_stays_shut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_active && !open_req) |=> !win_active);
endmodule

// File: rtl/tcr_deframer.sv
module tcr_deframer
  import tcr_pkg::*;
#(
  parameter int MAX_BYTES     = 40,
  parameter int SOT_LO_MIN    = 10,
  parameter int SOT_LO_MAX    = 11,
  parameter int SOT_HI_MIN    = 2,
  parameter int SOT_HI_MAX    = 3,
  parameter int GUARD_MAX     = 6,
  parameter int MIN_CRC_BYTES = 3,
  parameter int CRC_W         = 16,
  parameter logic [CRC_W-1:0] CRC_RESIDUE = '0,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_lvl,
  input  logic             sot_go,
  input  logic             crc_off,
  input  logic [CRC_W-1:0] crc_val,
  output logic             crc_init,
  output logic             crc_en,
  output logic [CHAR_BITS-1:0] crc_din,
  output logic             idle,
  output logic             byte_valid,
  output logic [CHAR_BITS-1:0] byte_data,
  output logic             byte_first,
  output logic             frame_done,
  output logic [LEN_W-1:0] frame_len,
  output logic             frame_err,
  output logic             crc_ok,
  output logic             overflow,
  output logic             eot_long
);
  localparam int CNT_W = $clog2(EOT_LO_LONG + 2);
  localparam logic [CNT_W-1:0] C_SLO_MIN = CNT_W'(SOT_LO_MIN);
  localparam logic [CNT_W-1:0] C_SLO_MAX = CNT_W'(SOT_LO_MAX);
  localparam logic [CNT_W-1:0] C_SHI_MIN = CNT_W'(SOT_HI_MIN);
  localparam logic [CNT_W-1:0] C_SHI_MAX = CNT_W'(SOT_HI_MAX);
  localparam logic [CNT_W-1:0] C_GMAX    = CNT_W'(GUARD_MAX);
  localparam logic [CNT_W-1:0] C_LAST_DB = CNT_W'(CHAR_BITS);
  localparam logic [CNT_W-1:0] C_EOT_S   = CNT_W'(EOT_LO_SHORT);
  localparam logic [CNT_W-1:0] C_EOT_L   = CNT_W'(EOT_LO_LONG);
  localparam logic [LEN_W-1:0] L_MAX     = LEN_W'(MAX_BYTES);
  localparam logic [LEN_W-1:0] L_MINCRC  = LEN_W'(MIN_CRC_BYTES);

  rx_state_e            state, nstate;
  logic [CNT_W-1:0]     cnt, ncnt;
  logic [CHAR_BITS-1:0] shreg;
  logic [LEN_W-1:0]     nbytes;
  logic                 ovf;
  logic                 shift, emit, fail, finish, long_n;

  assign idle     = (state == ST_IDLE);
  assign crc_init = sot_go;
  assign crc_en   = emit;
  assign crc_din  = shreg;

  always_comb begin
    nstate = state;
    ncnt   = cnt;
    shift  = 1'b0;
    emit   = 1'b0;
    fail   = 1'b0;
    finish = 1'b0;
    long_n = 1'b0;
    if (bit_stb) begin
      unique case (state)
        ST_SOT_LO:
          if (!rx_lvl) begin
            if (cnt == C_SLO_MAX) fail = 1'b1;
            else                  ncnt = cnt + 1'b1;
          end else if (cnt >= C_SLO_MIN) begin
            nstate = ST_SOT_HI;
            ncnt   = CNT_W'(1);
          end else fail = 1'b1;
        ST_SOT_HI:
          if (rx_lvl) begin
            if (cnt == C_SHI_MAX) fail = 1'b1;
            else                  ncnt = cnt + 1'b1;
          end else if (cnt >= C_SHI_MIN) begin
            nstate = ST_DATA;
            ncnt   = CNT_W'(1);
          end else fail = 1'b1;
        ST_DATA:
          if (cnt <= C_LAST_DB) begin
            shift = 1'b1;
            ncnt  = cnt + 1'b1;
          end else if (rx_lvl) begin
            emit   = 1'b1;
            nstate = ST_GUARD;
            ncnt   = '0;
          end else if (shreg == '0) begin
            nstate = ST_EOT;
            ncnt   = C_EOT_S;
          end else fail = 1'b1;
        ST_GUARD:
          if (rx_lvl) begin
            if (cnt == C_GMAX) fail = 1'b1;
            else               ncnt = cnt + 1'b1;
          end else begin
            nstate = ST_DATA;
            ncnt   = CNT_W'(1);
          end
        ST_EOT:
          if (!rx_lvl) begin
            if (cnt == C_EOT_L) fail = 1'b1;
            else                ncnt = cnt + 1'b1;
          end else begin
            finish = 1'b1;
            long_n = (cnt == C_EOT_L);
          end
        default: ;
      endcase
    end
    if (fail || finish) nstate = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      nbytes     <= '0;
      ovf        <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_first <= 1'b0;
      frame_done <= 1'b0;
      frame_len  <= '0;
      frame_err  <= 1'b0;
      crc_ok     <= 1'b0;
      overflow   <= 1'b0;
      eot_long   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_done <= 1'b0;
      if (sot_go) begin
        state  <= ST_SOT_LO;
        cnt    <= CNT_W'(1);
        nbytes <= '0;
        ovf    <= 1'b0;
      end else begin
        state <= nstate;
        cnt   <= ncnt;
        if (shift) shreg <= {rx_lvl, shreg[CHAR_BITS-1:1]};
        if (emit) begin
          if (nbytes == L_MAX) ovf <= 1'b1;
          else begin
            byte_valid <= 1'b1;
            byte_data  <= shreg;
            byte_first <= (nbytes == '0);
            nbytes     <= nbytes + 1'b1;
          end
        end
        if (fail || finish) begin
          frame_done <= 1'b1;
          frame_err  <= fail;
          frame_len  <= nbytes;
          overflow   <= ovf;
          eot_long   <= long_n;
          crc_ok     <= finish && (crc_off ||
                        (crc_val == CRC_RESIDUE && nbytes >= L_MINCRC));
        end
      end
    end
  end

  assert_byte_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(bit_stb));
  assert_done_without_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !byte_valid);
  assert_len_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len <= L_MAX));
endmodule

// File: rtl/tcr_reply.sv
module tcr_reply
  import tcr_pkg::*;
#(
  parameter int REPLY_GAP = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic frame_done,
  input  logic frame_err,
  input  logic eot_long,
  output logic pending,
  output logic reply_start
);
  localparam int REM_W = $clog2(REPLY_GAP + 1);
  localparam logic [REM_W-1:0] LOAD_S = REM_W'(REPLY_GAP - EOT_LO_SHORT);
  localparam logic [REM_W-1:0] LOAD_L = REM_W'(REPLY_GAP - EOT_LO_LONG);

  logic [REM_W-1:0] rem, rem_n;

  // strobes still to pass before the reply instant
  always_comb begin
    rem_n = rem;
    if (frame_done && !frame_err) rem_n = eot_long ? LOAD_L : LOAD_S;
  end

  assign pending = (rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem         <= '0;
      reply_start <= 1'b0;
    end else begin
      reply_start <= 1'b0;
      if (bit_stb && rem_n != '0) begin
        rem <= rem_n - 1'b1;
        if (rem_n == REM_W'(1)) reply_start <= 1'b1;
      end else begin
        rem <= rem_n;
      end
    end
  end

  assert_reply_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reply_start |-> $past(bit_stb));
endmodule

// File: rtl/tag_cmd_rx.sv
module tag_cmd_rx
  import tcr_pkg::*;
#(
  parameter int LISTEN_BITS = 8,
  parameter int MAX_BYTES   = 40,
  parameter int REPLY_GAP   = 12,
  parameter int GUARD_MAX   = 6,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_lvl,
  input  logic             listen_open,
  input  logic             crc_off,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_first,
  output logic             frame_done,
  output logic [LEN_W-1:0] frame_len,
  output logic             frame_err,
  output logic             crc_ok,
  output logic             overflow,
  output logic             reply_start
);
  localparam int CRC_W = 16;

  logic             win_active, sot_go, df_idle, rp_pending, busy;
  logic             crc_init, crc_en, eot_long;
  logic [7:0]       crc_din;
  logic [CRC_W-1:0] crc_val;

  assign busy = !df_idle || rp_pending;

  tcr_listen #(.LISTEN_BITS(LISTEN_BITS)) u_listen (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_lvl(rx_lvl),
    .open_req(listen_open), .busy(busy), .win_active(win_active), .sot_go(sot_go)
  );

  tcr_crc #(.CRC_W(CRC_W), .CRC_POLY(16'h1021), .CRC_INIT(16'hFFFF), .DATA_W(8)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en), .din(crc_din), .crc(crc_val)
  );

  tcr_deframer #(
    .MAX_BYTES(MAX_BYTES), .SOT_LO_MIN(10), .SOT_LO_MAX(11), .SOT_HI_MIN(2),
    .SOT_HI_MAX(3), .GUARD_MAX(GUARD_MAX), .MIN_CRC_BYTES(3), .CRC_W(CRC_W),
    .CRC_RESIDUE(16'h0000)
  ) u_deframer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_lvl(rx_lvl), .sot_go(sot_go),
    .crc_off(crc_off), .crc_val(crc_val), .crc_init(crc_init), .crc_en(crc_en),
    .crc_din(crc_din), .idle(df_idle), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_first(byte_first), .frame_done(frame_done), .frame_len(frame_len),
    .frame_err(frame_err), .crc_ok(crc_ok), .overflow(overflow), .eot_long(eot_long)
  );

  tcr_reply #(.REPLY_GAP(REPLY_GAP)) u_reply (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_done(frame_done),
    .frame_err(frame_err), .eot_long(eot_long), .pending(rp_pending),
    .reply_start(reply_start)
  );

  assert_sot_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(df_idle) |-> $past(win_active));
  assert_no_reply_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_err) |=> !reply_start);
endmodule

// File: tb/tag_cmd_rx_tb.sv
`timescale 1ns/1ps
module tag_cmd_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, rx_lvl = 1'b1;
  logic listen_open = 1'b0, crc_off = 1'b0;
  logic byte_valid, byte_first, frame_done, frame_err, crc_ok, overflow, reply_start;
  logic [7:0] byte_data;
  logic [5:0] frame_len;

  always #2.5 clk = ~clk;

  tag_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_lvl(rx_lvl),
    .listen_open(listen_open), .crc_off(crc_off), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_first(byte_first), .frame_done(frame_done),
    .frame_len(frame_len), .frame_err(frame_err), .crc_ok(crc_ok),
    .overflow(overflow), .reply_start(reply_start)
  );

  int n_chk = 0, n_fail = 0;
  int cur_idx = 0, eot_idx = 0;
  logic [7:0] tx [0:63];
  int tx_n = 0;
  logic [7:0] rx_b [0:63];
  logic rx_f [0:63];
  int rx_n = 0, done_cnt = 0, rep_cnt = 0, rep_idx = 0;
  int d_len = 0, d_err = 0, d_crc = 0, d_ovf = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (byte_valid && rx_n < 64) begin
      rx_b[rx_n] = byte_data;
      rx_f[rx_n] = byte_first;
      rx_n++;
    end
    if (frame_done) begin
      done_cnt++;
      d_len = frame_len; d_err = frame_err; d_crc = crc_ok; d_ovf = overflow;
    end
    if (reply_start) begin
      rep_cnt++;
      rep_idx = cur_idx;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk);
    rx_lvl = v; bit_stb = 1'b1; cur_idx++;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic open_win();
    @(negedge clk) listen_open = 1'b1;
    @(negedge clk) listen_open = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d, input logic stopv, input int g);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(stopv);
    repeat (g) send_bit(1'b1);
  endtask

  task automatic send_frame(input bit win, input int h, input int slo, input int shi,
                            input int g, input int elo);
    if (win) open_win();
    repeat (h) send_bit(1'b1);
    repeat (slo) send_bit(1'b0);
    repeat (shi) send_bit(1'b1);
    for (int i = 0; i < tx_n; i++) send_char(tx[i], 1'b1, g);
    eot_idx = cur_idx + 1;
    repeat (elo) send_bit(1'b0);
    repeat (4) send_bit(1'b1);
  endtask

  // CRC over queued bytes; append register bits 15 down to 0
  task automatic add_crc();
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int j = 0; j < tx_n; j++)
      for (int i = 0; i < 8; i++) begin
        fb = c[15] ^ tx[j][i];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    for (int i = 0; i < 8; i++) begin
      tx[tx_n][i]   = c[15-i];
      tx[tx_n+1][i] = c[7-i];
    end
    tx_n += 2;
  endtask

  task automatic expect_good(input string req, input int exp_crc);
    chk(req, "frame_done count", done_cnt, 1);
    chk(req, "frame_err", d_err, 0);
    chk(req, "frame_len", d_len, tx_n);
    chk(req, "crc_ok", d_crc, exp_crc);
    chk(req, "bytes seen", rx_n, tx_n);
    for (int i = 0; i < tx_n && i < rx_n; i++) begin
      chk("R2", "byte value", int'(rx_b[i]), int'(tx[i]));
      chk("R2", "first marker", int'(rx_f[i]), (i == 0) ? 1 : 0);
    end
    chk("R7", "reply count", rep_cnt, 1);
    chk("R7", "reply offset", rep_idx - eot_idx, 12);
  endtask

  task automatic clear_obs();
    rx_n = 0; done_cnt = 0; rep_cnt = 0;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int h, slo, shi, g, elo, n;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "byte_valid", byte_valid, 0);
    chk("R11", "frame_done", frame_done, 0);
    chk("R11", "reply_start", reply_start, 0);
    chk("R11", "frame_len", frame_len, 0);
    chk("R11", "flags", {frame_err, crc_ok, overflow}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // random clean frames (R1 R2 R3 R4 R5 R7)
    for (int k = 0; k < 10; k++) begin
      clear_obs();
      n = 1 + int'($urandom % 5);
      tx_n = n;
      for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
      add_crc();
      h = 1 + int'($urandom % 6);
      slo = 10 + int'($urandom % 2);
      shi = 2 + int'($urandom % 2);
      g = int'($urandom % 7);
      elo = 10 + int'($urandom % 2);
      send_frame(1, h, slo, shi, g, elo);
      expect_good("R5", 1);
    end

    // directed boundaries: longest runs and six guard bits (R3 R4)
    clear_obs(); tx_n = 2; tx[0] = 8'h00; tx[1] = 8'hFF; add_crc();
    send_frame(1, 6, 11, 3, 6, 11);
    expect_good("R4", 1);

    // R1 start-run faults
    clear_obs(); tx_n = 1; tx[0] = 8'h3C;
    send_frame(1, 2, 9, 2, 0, 10);
    chk("R1", "nine lows done", done_cnt, 1); chk("R1", "nine lows err", d_err, 1);
    chk("R1", "nine lows bytes", rx_n, 0);
    clear_obs(); send_frame(1, 2, 12, 2, 0, 10);
    chk("R1", "twelve lows err", d_err, 1); chk("R1", "twelve lows done", done_cnt, 1);
    clear_obs(); send_frame(1, 2, 10, 1, 0, 10);
    chk("R1", "one high err", d_err, 1); chk("R1", "one high done", done_cnt, 1);
    clear_obs(); send_frame(1, 2, 10, 4, 0, 10);
    chk("R1", "four highs err", d_err, 1); chk("R7", "no reply on fault", rep_cnt, 0);

    // R3 seven guard bits
    clear_obs(); tx_n = 2; tx[0] = 8'hA5; tx[1] = 8'h11;
    send_frame(1, 3, 10, 2, 7, 10);
    chk("R3", "guard err", d_err, 1); chk("R3", "bytes before fault", rx_n, 1);
    chk("R3", "no reply", rep_cnt, 0);

    // R4 low stop slot with nonzero data
    clear_obs(); open_win(); repeat (2) send_bit(1'b1);
    repeat (10) send_bit(1'b0); repeat (2) send_bit(1'b1);
    send_char(8'h5A, 1'b0, 0); repeat (12) send_bit(1'b1);
    chk("R4", "bad stop err", d_err, 1); chk("R4", "bad stop bytes", rx_n, 0);

    // R4 end run of twelve lows
    clear_obs(); tx_n = 1; tx[0] = 8'h42;
    send_frame(1, 2, 10, 2, 1, 12);
    chk("R4", "long end err", d_err, 1); chk("R4", "long end done", done_cnt, 1);
    chk("R7", "long end no reply", rep_cnt, 0);

    // R5 corrupted CRC, R6 check disabled
    clear_obs(); tx_n = 3; tx[0] = 8'h13; tx[1] = 8'h55; tx[2] = 8'h26; add_crc();
    tx[3] = tx[3] ^ 8'h08;
    send_frame(1, 1, 10, 2, 0, 10);
    expect_good("R5", 0);
    clear_obs(); crc_off = 1'b1;
    send_frame(1, 4, 11, 2, 2, 10);
    expect_good("R6", 1);
    crc_off = 1'b0;
    // R5 too short to carry a CRC
    clear_obs(); tx_n = 1; tx[0] = 8'h00;
    send_frame(1, 2, 10, 2, 0, 10);
    expect_good("R5", 0);

    // R8 first low at window position 0 and position 7: ignored
    clear_obs(); tx_n = 2; tx[0] = 8'h77; tx[1] = 8'h88;
    send_frame(1, 0, 10, 2, 0, 10);
    chk("R8", "slot0 done", done_cnt, 0); chk("R8", "slot0 bytes", rx_n, 0);
    chk("R8", "slot0 reply", rep_cnt, 0);
    clear_obs(); send_frame(1, 7, 10, 2, 0, 10);
    chk("R8", "slot7 done", done_cnt, 0); chk("R8", "slot7 bytes", rx_n, 0);
    // R9 no window at all
    clear_obs(); send_frame(0, 3, 10, 2, 0, 10);
    chk("R9", "closed done", done_cnt, 0); chk("R9", "closed bytes", rx_n, 0);
    chk("R9", "closed reply", rep_cnt, 0);
    // receiver still takes a frame afterwards
    clear_obs(); add_crc(); send_frame(1, 5, 10, 3, 0, 11);
    expect_good("R8", 1);

    // R10 overflow
    clear_obs(); crc_off = 1'b1; tx_n = 41;
    for (int i = 0; i < 41; i++) tx[i] = 8'(i * 7 + 1);
    send_frame(1, 2, 10, 2, 0, 10);
    chk("R10", "len", d_len, 40); chk("R10", "overflow", d_ovf, 1);
    chk("R10", "bytes", rx_n, 40); chk("R10", "err", d_err, 0);
    chk("R10", "last byte", int'(rx_b[39]), int'(tx[39]));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule